// File: doc/BRIEF.md
# Iterative AES-128 Encryption Core

This block encrypts 128-bit blocks under a 128-bit key with the AES-128 cipher. It computes one cipher round per clock cycle and derives each round key from the previous one in the same cycle, so no expanded key table is kept. A block and its key enter together through a valid/ready handshake. The ciphertext leaves on a register that is flagged by a one-cycle valid strobe and then held.

The first key addition (plaintext XOR key) happens in the cycle the block is accepted. Rounds 1 through 10 follow in the next ten cycles. The tenth round skips MixColumns but runs through the same round hardware. The core raises its ready output again during that final round, so a waiting producer can load the next block on the edge that completes the current one. A stream of blocks therefore yields one ciphertext every ten cycles. Decryption and the longer key sizes are not part of this block.

Top module: `aes128_iter_core`

## Requirements
- R1: While `rst` is high at a rising edge, the core goes idle. After that edge `out_valid` is 0, `in_ready` is 1 and `out_ct` is all zeros.
- R2: `in_ready` is 1 when the core is idle or in the last (tenth) round of a block, and 0 during rounds 1 to 9.
- R3: A block is accepted on a rising edge where `in_valid` and `in_ready` are both 1. Its ciphertext appears with `out_valid` = 1 in the eleventh cycle after the cycle of acceptance, that is, after ten further rising edges.
- R4: Key 000102030405060708090A0B0C0D0E0F and plaintext 00112233445566778899AABBCCDDEEFF give ciphertext 69C4E0D86A7B0430D8CDB78070B4C55A. Byte 0 sits in bits [127:120], and bytes fill the state column by column.
- R5: For any key and plaintext, `out_ct` equals AES-128 encryption. The key expansion uses round constants 01, 02, 04, 08, 10, 20, 40, 80, 1B, 36 in round order, and the tenth round has no MixColumns.
- R6: When `in_valid` is held high over a sequence of blocks, each new block is accepted in the final round of the previous one, and successive `out_valid` pulses are exactly 10 cycles apart.
- R7: `out_valid` is high for exactly one cycle per block. `out_ct` keeps its value until the next result is presented.
- R8: `in_valid` asserted during rounds 1 to 9 has no effect. The block in flight gives its correct ciphertext, and no extra result appears afterwards.
- R9: A reset while a block is in progress drops that block, and no `out_valid` pulse follows for it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Plaintext and key are presented |
| in_ready | output | 1 | Core can take a block on this edge |
| in_pt | input | 128 | Plaintext block, byte 0 in [127:120] |
| in_key | input | 128 | Cipher key, byte 0 in [127:120] |
| out_valid | output | 1 | One-cycle strobe: new ciphertext on out_ct |
| out_ct | output | 128 | Ciphertext, held between strobes |

## Verification
Any fault in a single round, in the key step or in the round-constant sequence spreads across the whole block within two rounds. A wrong internal value therefore changes roughly half the ciphertext bits at the very next strobe, eleven cycles after acceptance. A wrong round counter shows up as a strobe outside the eleventh cycle, as ready rising at the wrong time, or as a streaming interval other than ten cycles. These are checked on every block of a sweep of patterned and pseudo-random keys and plaintexts, each compared against an arithmetic model of the cipher.

// File: rtl/aes128_pkg.sv
package aes128_pkg;

    localparam int BLOCK_W   = 128;
    localparam int BYTE_W    = 8;
    localparam int NUM_BYTES = BLOCK_W / BYTE_W;
    localparam int NUM_ROUNDS = 10;
    localparam int RND_W     = $clog2(NUM_ROUNDS + 1);
    localparam logic [7:0] RCON_FIRST = 8'h01;
    localparam logic [7:0] INV_EXP    = 8'hFE;

    typedef struct packed {
        logic               busy;
        logic [RND_W-1:0]   rnd;
        logic [BLOCK_W-1:0] state;
        logic [BLOCK_W-1:0] key;
        logic [7:0]         rcon;
        logic [BLOCK_W-1:0] ct;
        logic               ovalid;
    } core_regs_t;

    // Doubling in GF(2^8): shift, then fold the carried bit back with 0x1B.
    function automatic logic [7:0] gf_dbl(input logic [7:0] b);
        return {b[6:0], 1'b0} ^ (b[7] ? 8'h1B : 8'h00);
    endfunction

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = 8'h00;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = gf_dbl(sh);
        end
        return acc;
    endfunction

    // Substitution: multiplicative inverse (x^254) then the affine map.
    function automatic logic [7:0] sub_byte(input logic [7:0] x);
        logic [7:0] r;
        r = 8'h01;
        for (int i = 7; i >= 0; i--) begin
            r = gf_mul(r, r);
            if (INV_EXP[i]) r = gf_mul(r, x);
        end
        return r ^ {r[6:0], r[7]} ^ {r[5:0], r[7:6]} ^ {r[4:0], r[7:5]}
                 ^ {r[3:0], r[7:4]} ^ 8'h63;
    endfunction

endpackage

// File: rtl/aes128_keystep.sv
module aes128_keystep
    import aes128_pkg::*;
(
    input  logic [BLOCK_W-1:0] key_cur,
    input  logic [7:0]         rcon,
    output logic [BLOCK_W-1:0] key_nxt
);
    localparam int WORDS = BLOCK_W / 32;

    logic [31:0] w_cur [WORDS];
    logic [31:0] w_nxt [WORDS];
    logic [31:0] t_word;

    generate
        for (genvar w = 0; w < WORDS; w++) begin : g_words
            assign w_cur[w] = key_cur[BLOCK_W-1-32*w -: 32];
            assign key_nxt[BLOCK_W-1-32*w -: 32] = w_nxt[w];
        end
    endgenerate

    // Rotate the last word by one byte, substitute, add the round constant.
    assign t_word = {sub_byte(w_cur[WORDS-1][23:16]) ^ rcon,
                     sub_byte(w_cur[WORDS-1][15:8]),
                     sub_byte(w_cur[WORDS-1][7:0]),
                     sub_byte(w_cur[WORDS-1][31:24])};

    assign w_nxt[0] = w_cur[0] ^ t_word;
    generate
        for (genvar w = 1; w < WORDS; w++) begin : g_chain
            assign w_nxt[w] = w_cur[w] ^ w_nxt[w-1];
        end
    endgenerate
endmodule

// File: rtl/aes128_round.sv
module aes128_round
    import aes128_pkg::*;
(
    input  logic [BLOCK_W-1:0] st_in,
    input  logic [BLOCK_W-1:0] rkey,
    input  logic               skip_mix,
    output logic [BLOCK_W-1:0] st_out
);
    logic [7:0] subd [NUM_BYTES];
    logic [7:0] shft [NUM_BYTES];
    logic [7:0] mixd [NUM_BYTES];

    generate
        for (genvar i = 0; i < NUM_BYTES; i++) begin : g_sub
            assign subd[i] = sub_byte(st_in[BLOCK_W-1-BYTE_W*i -: BYTE_W]);
        end
        // Row r of column c takes row r of column (c + r) mod 4.
        for (genvar c = 0; c < 4; c++) begin : g_col
            for (genvar r = 0; r < 4; r++) begin : g_row
                assign shft[r + 4*c] = subd[r + 4*((c + r) % 4)];
            end
            logic [7:0] a0, a1, a2, a3;
            assign a0 = shft[4*c];
            assign a1 = shft[4*c+1];
            assign a2 = shft[4*c+2];
            assign a3 = shft[4*c+3];
            assign mixd[4*c]   = skip_mix ? a0 : gf_dbl(a0) ^ gf_dbl(a1) ^ a1 ^ a2 ^ a3;
            assign mixd[4*c+1] = skip_mix ? a1 : a0 ^ gf_dbl(a1) ^ gf_dbl(a2) ^ a2 ^ a3;
            assign mixd[4*c+2] = skip_mix ? a2 : a0 ^ a1 ^ gf_dbl(a2) ^ gf_dbl(a3) ^ a3;
            assign mixd[4*c+3] = skip_mix ? a3 : gf_dbl(a0) ^ a0 ^ a1 ^ a2 ^ gf_dbl(a3);
        end
        for (genvar i = 0; i < NUM_BYTES; i++) begin : g_ark
            assign st_out[BLOCK_W-1-BYTE_W*i -: BYTE_W] =
                mixd[i] ^ rkey[BLOCK_W-1-BYTE_W*i -: BYTE_W];
        end
    endgenerate
endmodule

// File: rtl/aes128_iter_core.sv
module aes128_iter_core
    import aes128_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [BLOCK_W-1:0] in_pt,
    input  logic [BLOCK_W-1:0] in_key,
    output logic               out_valid,
    output logic [BLOCK_W-1:0] out_ct
);
    localparam logic [RND_W-1:0] LAST_RND = RND_W'(NUM_ROUNDS);
    localparam logic [RND_W-1:0] FIRST_RND = RND_W'(1);

    core_regs_t regs_q, regs_d;
    logic [BLOCK_W-1:0] rkey_nxt;
    logic [BLOCK_W-1:0] round_res;
    logic               last_rnd;
    logic               take;

    assign last_rnd = regs_q.busy && (regs_q.rnd == LAST_RND);

    aes128_keystep u_keystep (
        .key_cur (regs_q.key),
        .rcon    (regs_q.rcon),
        .key_nxt (rkey_nxt)
    );

    aes128_round u_round (
        .st_in    (regs_q.state),
        .rkey     (rkey_nxt),
        .skip_mix (last_rnd),
        .st_out   (round_res)
    );

    assign in_ready  = !regs_q.busy || last_rnd;
    assign take      = in_valid && in_ready;
    assign out_valid = regs_q.ovalid;
    assign out_ct    = regs_q.ct;

    always_comb begin
        regs_d        = regs_q;
        regs_d.ovalid = 1'b0;
        if (regs_q.busy) begin
            regs_d.state = round_res;
            regs_d.key   = rkey_nxt;
            regs_d.rcon  = gf_dbl(regs_q.rcon);
            regs_d.rnd   = regs_q.rnd + RND_W'(1);
            if (last_rnd) begin
                regs_d.busy   = 1'b0;
                regs_d.ct     = round_res;
                regs_d.ovalid = 1'b1;
            end
        end
        if (take) begin
            regs_d.busy  = 1'b1;
            regs_d.rnd   = FIRST_RND;
            regs_d.state = in_pt ^ in_key;
            regs_d.key   = in_key;
            regs_d.rcon  = RCON_FIRST;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    // R1: reset leaves the core idle with no result flagged.
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && in_ready && out_ct == '0));

    // R3: an accepted block starts at round one on the next cycle.
    assert_accept_starts_R3: assert property (@(posedge clk) disable iff (rst)
        take |=> (regs_q.busy && regs_q.rnd == FIRST_RND));

    // R3: round counter stays within 1..10 while busy.
    assert_round_range_R3: assert property (@(posedge clk) disable iff (rst)
        regs_q.busy |-> (regs_q.rnd >= FIRST_RND && regs_q.rnd <= LAST_RND));

    // R5: round constant is always a member of the AES-128 sequence.
    assert_rcon_legal_R5: assert property (@(posedge clk) disable iff (rst)
        regs_q.busy |-> ($onehot(regs_q.rcon) || regs_q.rcon == 8'h1B || regs_q.rcon == 8'h36));

    // R6: a result always follows a cycle in which ready was offered.
    assert_ready_before_result_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_ready));

    // R7: strobe lasts one cycle.
    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R7: ciphertext is held between strobes.
    assert_ct_held_R7: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_ct));
endmodule

// File: tb/aes128_iter_core_bench.sv
module aes128_iter_core_bench;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [127:0] in_pt = '0;
    logic [127:0] in_key = '0;
    logic         out_valid;
    logic [127:0] out_ct;

    int total = 0;
    int fails = 0;
    logic [7:0] sb [256];
    logic [63:0] rng = 64'h9E3779B97F4A7C15;

    always #5 clk = ~clk;

    aes128_iter_core u_aes128_iter_core (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_pt(in_pt), .in_key(in_key), .out_valid(out_valid), .out_ct(out_ct)
    );

    // ---------------- reference model ----------------
    function automatic logic [7:0] mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p = 8'h00;
        logic [7:0] x = a;
        logic [7:0] y = b;
        while (y != 0) begin
            if (y[0]) p ^= x;
            x = x[7] ? ((x << 1) ^ 8'h1B) : (x << 1);
            y = y >> 1;
        end
        return p;
    endfunction

    function automatic void build_sbox();
        for (int v = 0; v < 256; v++) begin
            logic [7:0] inv = 8'h00;
            logic [7:0] s;
            for (int y = 1; y < 256; y++)
                if (v != 0 && mul(8'(v), 8'(y)) == 8'h01) inv = 8'(y);
            s = 8'h63;
            for (int k = 0; k < 5; k++) s ^= ((inv << k) | (inv >> (8 - k)));
            sb[v] = s;
        end
    endfunction

    function automatic logic [7:0] byt(input logic [127:0] v, input int i);
        return v[127 - 8*i -: 8];
    endfunction

    function automatic logic [127:0] ref_enc(input logic [127:0] pt, input logic [127:0] key);
        logic [7:0] s [16];
        logic [7:0] t [16];
        logic [7:0] k [16];
        logic [7:0] rc = 8'h01;
        logic [127:0] res;
        for (int i = 0; i < 16; i++) begin
            k[i] = byt(key, i);
            s[i] = byt(pt, i) ^ k[i];
        end
        for (int r = 1; r <= 10; r++) begin
            logic [7:0] g [4];
            g[0] = sb[k[13]] ^ rc; g[1] = sb[k[14]]; g[2] = sb[k[15]]; g[3] = sb[k[12]];
            for (int i = 0; i < 16; i++)
                k[i] = k[i] ^ ((i < 4) ? g[i] : k[i-4]);
            for (int c = 0; c < 4; c++)
                for (int rw = 0; rw < 4; rw++)
                    t[rw + 4*c] = sb[s[rw + 4*((c + rw) % 4)]];
            for (int c = 0; c < 4; c++)
                for (int rw = 0; rw < 4; rw++)
                    if (r < 10)
                        s[rw + 4*c] = mul(8'h02, t[4*c + rw]) ^ mul(8'h03, t[4*c + (rw+1)%4])
                                    ^ t[4*c + (rw+2)%4] ^ t[4*c + (rw+3)%4];
                    else
                        s[rw + 4*c] = t[rw + 4*c];
            for (int i = 0; i < 16; i++) s[i] ^= k[i];
            rc = mul(rc, 8'h02);
        end
        for (int i = 0; i < 16; i++) res[127 - 8*i -: 8] = s[i];
        return res;
    endfunction

    function automatic logic [127:0] rnd128();
        logic [127:0] v;
        for (int h = 0; h < 2; h++) begin
            rng ^= rng << 13; rng ^= rng >> 7; rng ^= rng << 17;
            v = {v[63:0], rng};
        end
        return v;
    endfunction

    // ---------------- check helpers ----------------
    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_one(input logic [127:0] pt, input logic [127:0] key,
                            input int junk_at, input string req);
        logic [127:0] exp = ref_enc(pt, key);
        int n;
        bit rdy_bad = 1'b0;
        int extra = 0;
        @(negedge clk);
        in_valid = 1'b1; in_pt = pt; in_key = key;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        n = 1;
        while (!out_valid && n < 20) begin
            if (in_ready != (n == 10)) rdy_bad = 1'b1;
            if (n == junk_at) begin
                in_valid = 1'b1; in_pt = ~pt; in_key = ~key;
            end else begin
                in_valid = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        in_valid = 1'b0;
        chk(n == 11, "R3 latency", 128'(n), 128'd11);
        chk(out_ct == exp, req, out_ct, exp);
        chk(!rdy_bad, "R2 ready pattern", 128'(rdy_bad), 128'd0);
        @(negedge clk);
        chk(!out_valid && out_ct == exp, "R7 pulse and hold", {127'd0, out_valid}, 128'd0);
        if (junk_at > 0) begin
            for (int c = 0; c < 14; c++) begin
                if (out_valid) extra++;
                @(negedge clk);
            end
            chk(extra == 0 && out_ct == exp, "R8 ignored input", 128'(extra), 128'd0);
        end
    endtask

    task automatic stream(input int nblk);
        logic [127:0] pts [16];
        logic [127:0] keys [16];
        int idx = 0;
        int outs = 0;
        int cyc = 0;
        int last = 0;
        for (int b = 0; b < nblk; b++) begin
            pts[b] = rnd128(); keys[b] = rnd128();
        end
        while (outs < nblk && cyc < 400) begin
            @(negedge clk);
            cyc++;
            if (out_valid) begin
                logic [127:0] e = ref_enc(pts[outs], keys[outs]);
                chk(out_ct == e, "R5 streamed ciphertext", out_ct, e);
                if (outs > 0) chk(cyc - last == 10, "R6 output interval", 128'(cyc - last), 128'd10);
                last = cyc;
                outs++;
            end
            if (idx < nblk) begin
                in_valid = 1'b1; in_pt = pts[idx]; in_key = keys[idx];
                if (in_ready) idx++;
            end else begin
                in_valid = 1'b0;
            end
        end
        in_valid = 1'b0;
        chk(outs == nblk, "R6 stream complete", 128'(outs), 128'(nblk));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int quiet;
        build_sbox();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: state right after reset
        chk(!out_valid && in_ready && out_ct == '0, "R1 reset state",
            {126'd0, out_valid, in_ready}, 128'd1);

        // R4: standard vector; the model itself is checked against it too
        chk(ref_enc(128'h00112233445566778899AABBCCDDEEFF, 128'h000102030405060708090A0B0C0D0E0F)
            == 128'h69C4E0D86A7B0430D8CDB78070B4C55A, "R4 bench model",
            ref_enc(128'h00112233445566778899AABBCCDDEEFF, 128'h000102030405060708090A0B0C0D0E0F),
            128'h69C4E0D86A7B0430D8CDB78070B4C55A);
        send_one(128'h00112233445566778899AABBCCDDEEFF, 128'h000102030405060708090A0B0C0D0E0F,
                 0, "R4 standard vector");

        // R5: patterned corners then a pseudo-random sweep
        send_one('0, '0, 0, "R5 zero block zero key");
        send_one('1, '1, 0, "R5 ones block ones key");
        send_one('0, '1, 0, "R5 zero block ones key");
        send_one({16{8'hA5}}, {16{8'h5A}}, 0, "R5 alternating");
        for (int b = 0; b < 24; b++) send_one(rnd128(), rnd128(), 0, "R5 sweep");

        // R8: input offered mid-block is ignored
        send_one(rnd128(), rnd128(), 4, "R8 block with mid input");
        send_one(rnd128(), rnd128(), 9, "R8 block with round-9 input");

        // R6: back-to-back stream
        stream(12);

        // R9: reset mid-block drops it
        @(negedge clk);
        in_valid = 1'b1; in_pt = rnd128(); in_key = rnd128();
        @(negedge clk);
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        quiet = 0;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (out_valid || !in_ready) quiet++;
        end
        chk(quiet == 0, "R9 dropped block", 128'(quiet), 128'd0);
        chk(out_ct == '0, "R9 R1 output cleared", out_ct, '0);
        send_one(rnd128(), rnd128(), 0, "R9 recovery after reset");

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule